// File: doc/BRIEF.md
# Physical memory protection checker

This block keeps a small, parameterised bank of protection regions and judges every load, store and instruction fetch that a processor core presents to it. Each region has an 8-bit setting (read, write and execute grants, an address-matching rule and a lock bit) and an address register. The core asks for a verdict one access at a time and gets back, one clock later, a fault flag with the exception cause code it should raise.

Software programs the regions through a control-register port that reads combinationally and writes on the clock edge. The settings of four regions are packed into one 32-bit word. The number of regions and the address granularity are parameters. Software can find both by probing: address registers beyond the region count report an illegal access, and the low address bits below the granule always read back as zero. A mode that the build cannot honour is refused on write, so software detects it by reading the setting back. The port also flags a less-privileged attempt to reach any machine-level register number.

Top module: `pmp_guard`

## Requirements
- R1: Setting word k lives at register number 0x3A0+k, and its byte j (bits 8j+7:8j) belongs to region 4k+j. Region i's address register lives at 0x3B0+i. Read data follows the number combinationally in the same cycle. A write takes effect at the clock edge. Setting bytes of regions at or above NUM_REGIONS read as zero.
- R2: An access to address register 0x3B0+i with i >= NUM_REGIONS, or to a setting word that holds no implemented region, raises csr_illegal, reads zero and changes nothing.
- R3: When csr_priv is not 2'b11 (machine), any register number whose bits 9:8 are non-zero (for example 0x300 or 0x3A0) raises csr_illegal, and a write attempted that way changes nothing.
- R4: An address register stores bits 29:0 of the written word with the low GRAN bits cleared, and bits 31:30 read as zero. With GRAN=2, writing all ones reads back 0x3FFFFFFC; with GRAN=0 it reads back 0x3FFFFFFF.
- R5: Setting byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (00 off, 01 TOR, 10 NA4, 11 NAPOT), bit 7 lock, bits 6:5 always read zero. A byte that asks for NA4 when GRAN > 0 is refused, and the old byte is kept. TOR (0x08) and NAPOT (0x18) bytes read back as written.
- R6: TOR region i matches word address acc_addr[31:2] in [lower, addr_i), where lower is region i-1's address register (whatever that region's mode) and 0 for region 0.
- R7: NA4 region i matches the single 4-byte word whose word address acc_addr[31:2] equals addr_i.
- R8: NAPOT uses addr_i with its low GRAN bits forced to ones. Its t trailing ones select an aligned region of 2^(t+3) bytes. The value 0x1FFF covers bytes 0x0 to 0xFFFF.
- R9: When several regions match, the lowest-numbered one alone decides the outcome.
- R10: A user access (acc_priv != 2'b11) to a matched region faults when the region lacks the needed grant. Loads need read, stores need write and fetches need execute. acc_kind is 00 load, 01 store, 10 fetch, with 11 treated as a load. The cause is 5 for a load, 7 for a store and 1 for a fetch, and it is 0 when there is no fault.
- R11: A user access that matches no region faults if at least one region is not off, and passes if every region is off.
- R12: A machine access passes unless it matches a region that has its lock bit set and lacks the needed grant. A locked region ignores writes to its setting byte and its address register until reset. Unlocked neighbours in the same word stay writable.
- R13: resp_valid is high exactly in the cycle after each cycle with acc_valid high. resp_fault and resp_cause describe that access against the region state at the edge that sampled it.
- R14: After reset every region is off, every address register is zero and resp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_en | input | 1 | Register port access strobe |
| csr_we | input | 1 | Register port write when high, read when low |
| csr_addr | input | 12 | Register number |
| csr_wdata | input | 32 | Write data |
| csr_priv | input | 2 | Privilege of the register access (2'b11 machine) |
| csr_rdata | output | 32 | Read data, combinational |
| csr_illegal | output | 1 | Access refused as an illegal instruction |
| acc_valid | input | 1 | Memory access to judge this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch |
| acc_priv | input | 2 | Privilege of the access (2'b11 machine) |
| resp_valid | output | 1 | Verdict available |
| resp_fault | output | 1 | Access fault |
| resp_cause | output | 4 | Exception cause code, 0 when no fault |

## Verification
Every cycle, the assertions check the response handshake timing, and that each cause code agrees with the access kind and is zero without a fault. They also check that refused and less-privileged register accesses read zero and are flagged, that reserved and sub-granule bits read zero, and that a locked setting byte never changes between reads. Only the bench scenarios can show the matching geometry: TOR bounds taken from the neighbour register, NA4 word hits, NAPOT size from trailing ones, and lowest-region priority. The same holds for refused NA4 writes, region-count probing and the machine-mode lock behaviour, because those need programmed region layouts and known addresses.

// File: rtl/pmp_guard_pkg.sv
`timescale 1ns/1ps
package pmp_guard_pkg;

  localparam int XLEN        = 32;
  localparam int WADDR_W     = 30;
  localparam int MAX_REGIONS = 16;

  localparam logic [11:0] CSR_CFG_BASE  = 12'h3A0;
  localparam logic [11:0] CSR_ADDR_BASE = 12'h3B0;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'b00,
    MATCH_TOR   = 2'b01,
    MATCH_NA4   = 2'b10,
    MATCH_NAPOT = 2'b11
  } match_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_STORE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } kind_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    match_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } region_cfg_t;

  localparam logic [3:0] CAUSE_NONE  = 4'd0;
  localparam logic [3:0] CAUSE_FETCH = 4'd1;
  localparam logic [3:0] CAUSE_LOAD  = 4'd5;
  localparam logic [3:0] CAUSE_STORE = 4'd7;

endpackage

// File: rtl/pmp_csr_bank.sv
`timescale 1ns/1ps
module pmp_csr_bank
  import pmp_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int GRAN        = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   csr_en,
  input  logic                                   csr_we,
  input  logic [11:0]                            csr_addr,
  input  logic [XLEN-1:0]                        csr_wdata,
  input  logic [1:0]                             csr_priv,
  output logic [XLEN-1:0]                        csr_rdata,
  output logic                                   csr_illegal,
  output region_cfg_t [NUM_REGIONS-1:0]          cfg_o,
  output logic [NUM_REGIONS-1:0][WADDR_W-1:0]    addr_o
);

  localparam logic [WADDR_W-1:0] GRAN_MASK = WADDR_W'((64'd1 << GRAN) - 64'd1);
  localparam bit                 NA4_OK    = (GRAN == 0);

  region_cfg_t [NUM_REGIONS-1:0]       cfg_q, cfg_d;
  logic [NUM_REGIONS-1:0][WADDR_W-1:0] addr_q, addr_d;

  logic       is_cfg, is_addr, cfg_impl, addr_impl, priv_fail;
  logic [1:0] cfg_idx;
  logic [3:0] addr_idx;
  logic       wr_ok, cfg_en, addr_en;

  // register number decode and refusal
  always_comb begin
    is_cfg    = (csr_addr[11:2] == CSR_CFG_BASE[11:2]);
    is_addr   = (csr_addr[11:4] == CSR_ADDR_BASE[11:4]);
    cfg_idx   = csr_addr[1:0];
    addr_idx  = csr_addr[3:0];
    cfg_impl  = (int'(cfg_idx) * 4 < NUM_REGIONS);
    addr_impl = (int'(addr_idx) < NUM_REGIONS);
    priv_fail = (csr_priv != PRIV_MACHINE) && (csr_addr[9:8] != 2'b00);
    csr_illegal = csr_en && (priv_fail || (is_cfg && !cfg_impl) ||
                             (is_addr && !addr_impl));
    wr_ok   = csr_en && csr_we && !csr_illegal;
    cfg_en  = wr_ok && is_cfg;
    addr_en = wr_ok && is_addr;
  end

  // next state with write filtering
  always_comb begin
    logic [7:0] nb;
    nb     = '0;
    cfg_d  = cfg_q;
    addr_d = addr_q;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (cfg_en && (cfg_idx == 2'(i / 4)) && !cfg_q[i].lock) begin
        nb = csr_wdata[8*(i%4) +: 8];
        if (!((nb[4:3] == MATCH_NA4) && !NA4_OK)) begin
          cfg_d[i] = region_cfg_t'({nb[7], 2'b00, nb[4:0]});
        end
      end
      if (addr_en && (addr_idx == 4'(i)) && !cfg_q[i].lock) begin
        addr_d[i] = csr_wdata[WADDR_W-1:0] & ~GRAN_MASK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  // read mux
  always_comb begin
    csr_rdata = '0;
    if (csr_en && !csr_illegal) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (is_cfg && (cfg_idx == 2'(i / 4))) begin
          csr_rdata[8*(i%4) +: 8] = cfg_q[i];
        end
        if (is_addr && (addr_idx == 4'(i))) begin
          csr_rdata = {{(XLEN-WADDR_W){1'b0}}, addr_q[i]};
        end
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/pmp_region_match.sv
`timescale 1ns/1ps
module pmp_region_match
  import pmp_guard_pkg::*;
#(
  parameter int GRAN = 2
) (
  input  match_e               mode,
  input  logic [WADDR_W-1:0]   addr_cur,
  input  logic [WADDR_W-1:0]   addr_prev,
  input  logic [WADDR_W-1:0]   word,
  output logic                 hit
);

  localparam logic [WADDR_W-1:0] GRAN_MASK = WADDR_W'((64'd1 << GRAN) - 64'd1);

  logic [WADDR_W-1:0] napot_eff, napot_low;
  logic               tor_hit, na4_hit, napot_hit;

  always_comb begin
    napot_eff = addr_cur | GRAN_MASK;
    napot_low = napot_eff ^ (napot_eff + 1'b1);
    napot_hit = (((word ^ napot_eff) & ~napot_low) == '0);
    tor_hit   = (word >= addr_prev) && (word < addr_cur);
    na4_hit   = (word == addr_cur);
    unique case (mode)
      MATCH_TOR:   hit = tor_hit;
      MATCH_NA4:   hit = na4_hit;
      MATCH_NAPOT: hit = napot_hit;
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_decide.sv
`timescale 1ns/1ps
module pmp_decide
  import pmp_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  input  logic [1:0]                    acc_kind,
  input  logic [1:0]                    acc_priv,
  input  logic [NUM_REGIONS-1:0]        hit_i,
  input  region_cfg_t [NUM_REGIONS-1:0] cfg_i,
  output logic                          resp_valid,
  output logic                          resp_fault,
  output logic [3:0]                    resp_cause
);

  region_cfg_t sel;
  logic        found, any_en, grant, machine, allow, fault_d;
  logic [3:0]  cause_d;

  // lowest-numbered hit wins
  always_comb begin
    found  = 1'b0;
    sel    = '0;
    any_en = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (cfg_i[i].mode != MATCH_OFF) any_en = 1'b1;
      if (hit_i[i]) begin
        found = 1'b1;
        sel   = cfg_i[i];
      end
    end
  end

  always_comb begin
    machine = (acc_priv == PRIV_MACHINE);
    unique case (acc_kind)
      KIND_STORE: begin grant = sel.w; cause_d = CAUSE_STORE; end
      KIND_FETCH: begin grant = sel.x; cause_d = CAUSE_FETCH; end
      default:    begin grant = sel.r; cause_d = CAUSE_LOAD;  end
    endcase
    if (found) allow = grant || (machine && !sel.lock);
    else       allow = machine || !any_en;
    fault_d = acc_valid && !allow;
    if (!fault_d) cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_cause <= CAUSE_NONE;
    end else begin
      resp_valid <= acc_valid;
      resp_fault <= fault_d;
      resp_cause <= cause_d;
    end
  end

endmodule

// File: rtl/pmp_guard.sv
`timescale 1ns/1ps
module pmp_guard
  import pmp_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int GRAN        = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_en,
  input  logic        csr_we,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  input  logic [1:0]  csr_priv,
  output logic [31:0] csr_rdata,
  output logic        csr_illegal,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic [1:0]  acc_kind,
  input  logic [1:0]  acc_priv,
  output logic        resp_valid,
  output logic        resp_fault,
  output logic [3:0]  resp_cause
);

  localparam int WORD_LSB = XLEN - WADDR_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  region_cfg_t [NUM_REGIONS-1:0]       cfg;
  logic [NUM_REGIONS-1:0][WADDR_W-1:0] addr;
  logic [NUM_REGIONS-1:0]              hit;
  logic [WADDR_W-1:0]                  word;

  assign word = acc_addr[XLEN-1:WORD_LSB];

  pmp_csr_bank #(.NUM_REGIONS(NUM_REGIONS), .GRAN(GRAN)) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .csr_en      (csr_en),
    .csr_we      (csr_we),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_priv    (csr_priv),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .cfg_o       (cfg),
    .addr_o      (addr)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic [WADDR_W-1:0] lower;
    if (g == 0) begin : g_first
      assign lower = '0;
    end else begin : g_next
      assign lower = addr[g-1];
    end
    pmp_region_match #(.GRAN(GRAN)) u_match (
      .mode      (cfg[g].mode),
      .addr_cur  (addr[g]),
      .addr_prev (lower),
      .word      (word),
      .hit       (hit[g])
    );
  end

  pmp_decide #(.NUM_REGIONS(NUM_REGIONS)) u_decide (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .acc_valid  (acc_valid),
    .acc_kind   (acc_kind),
    .acc_priv   (acc_priv),
    .hit_i      (hit),
    .cfg_i      (cfg),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_cause (resp_cause)
  );

endmodule

// File: rtl/pmp_guard_chk.sv
`timescale 1ns/1ps
module pmp_guard_chk #(
  parameter int GRAN = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_en,
  input logic        csr_we,
  input logic [11:0] csr_addr,
  input logic [1:0]  csr_priv,
  input logic [31:0] csr_rdata,
  input logic        csr_illegal,
  input logic        acc_valid,
  input logic [1:0]  acc_kind,
  input logic        resp_valid,
  input logic        resp_fault,
  input logic [3:0]  resp_cause
);

  localparam logic [31:0] LOW_MASK = 32'((64'd1 << GRAN) - 64'd1);

  logic rd_cfg0;
  assign rd_cfg0 = csr_en && !csr_illegal && (csr_addr == 12'h3A0);

  a_r13_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> resp_valid);

  a_r13_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !resp_valid);

  a_r10_cause_zero_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> (resp_cause == 4'd0));

  a_r10_store_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'b01) |=> (!resp_fault || resp_cause == 4'd7));

  a_r10_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'b10) |=> (!resp_fault || resp_cause == 4'd1));

  a_r10_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind[1] == acc_kind[0]) |=> (!resp_fault || resp_cause == 4'd5));

  a_r3_user_machine_csr: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_priv != 2'b11 && csr_addr[9:8] != 2'b00) |-> csr_illegal);

  a_r2_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == 32'd0));

  a_r4_gran_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && !csr_illegal && csr_addr[11:4] == 8'h3B) |->
      ((csr_rdata & LOW_MASK) == 32'd0 && csr_rdata[31:30] == 2'b00));

  a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && !csr_illegal && csr_addr[11:2] == 10'h0E8) |->
      ((csr_rdata & 32'h6060_6060) == 32'd0));

  a_r12_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cfg0 && csr_rdata[7]) |=>
      (!rd_cfg0 || csr_rdata[7:0] == $past(csr_rdata[7:0])));

endmodule

bind pmp_guard pmp_guard_chk #(.GRAN(GRAN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .csr_en      (csr_en),
  .csr_we      (csr_we),
  .csr_addr    (csr_addr),
  .csr_priv    (csr_priv),
  .csr_rdata   (csr_rdata),
  .csr_illegal (csr_illegal),
  .acc_valid   (acc_valid),
  .acc_kind    (acc_kind),
  .resp_valid  (resp_valid),
  .resp_fault  (resp_fault),
  .resp_cause  (resp_cause)
);

// File: tb/pmp_guard_test.sv
`timescale 1ns/1ps
module pmp_guard_test;

  localparam logic [1:0] PU = 2'b00, PM = 2'b11;
  localparam logic [1:0] KL = 2'b00, KS = 2'b01, KF = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // index 0: uut (4 regions, GRAN=2); index 1: uut_g0 (2 regions, GRAN=0)
  logic        csr_en    [2] = '{1'b0, 1'b0};
  logic        csr_we    [2] = '{1'b0, 1'b0};
  logic [11:0] csr_addr  [2] = '{12'h0, 12'h0};
  logic [31:0] csr_wdata [2] = '{32'h0, 32'h0};
  logic [1:0]  csr_priv  [2] = '{2'b11, 2'b11};
  logic [31:0] csr_rdata [2];
  logic        csr_ill   [2];
  logic        acc_valid [2] = '{1'b0, 1'b0};
  logic [31:0] acc_addr  [2] = '{32'h0, 32'h0};
  logic [1:0]  acc_kind  [2] = '{2'b00, 2'b00};
  logic [1:0]  acc_priv  [2] = '{2'b00, 2'b00};
  logic        resp_valid[2];
  logic        resp_fault[2];
  logic [3:0]  resp_cause[2];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  pmp_guard #(.NUM_REGIONS(4), .GRAN(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .csr_en(csr_en[0]), .csr_we(csr_we[0]), .csr_addr(csr_addr[0]),
    .csr_wdata(csr_wdata[0]), .csr_priv(csr_priv[0]),
    .csr_rdata(csr_rdata[0]), .csr_illegal(csr_ill[0]),
    .acc_valid(acc_valid[0]), .acc_addr(acc_addr[0]), .acc_kind(acc_kind[0]),
    .acc_priv(acc_priv[0]), .resp_valid(resp_valid[0]),
    .resp_fault(resp_fault[0]), .resp_cause(resp_cause[0]));

  pmp_guard #(.NUM_REGIONS(2), .GRAN(0)) uut_g0 (
    .clk(clk), .rst_n(rst_n),
    .csr_en(csr_en[1]), .csr_we(csr_we[1]), .csr_addr(csr_addr[1]),
    .csr_wdata(csr_wdata[1]), .csr_priv(csr_priv[1]),
    .csr_rdata(csr_rdata[1]), .csr_illegal(csr_ill[1]),
    .acc_valid(acc_valid[1]), .acc_addr(acc_addr[1]), .acc_kind(acc_kind[1]),
    .acc_priv(acc_priv[1]), .resp_valid(resp_valid[1]),
    .resp_fault(resp_fault[1]), .resp_cause(resp_cause[1]));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic csr_write(int u, logic [11:0] a, logic [31:0] d, logic [1:0] p);
    @(negedge clk);
    csr_en[u] = 1'b1; csr_we[u] = 1'b1; csr_addr[u] = a; csr_wdata[u] = d; csr_priv[u] = p;
    @(negedge clk);
    csr_en[u] = 1'b0; csr_we[u] = 1'b0; csr_priv[u] = PM;
  endtask

  task automatic expect_read(int u, logic [11:0] a, logic [1:0] p,
                             logic [31:0] exp_d, logic exp_ill, string req);
    @(negedge clk);
    csr_en[u] = 1'b1; csr_we[u] = 1'b0; csr_addr[u] = a; csr_priv[u] = p;
    #1;
    check(req, $sformatf("rdata @%03h", a), csr_rdata[u], exp_d);
    check(req, $sformatf("illegal @%03h", a), 32'(csr_ill[u]), 32'(exp_ill));
    csr_en[u] = 1'b0; csr_priv[u] = PM;
  endtask

  task automatic expect_access(int u, logic [31:0] a, logic [1:0] k, logic [1:0] p,
                               logic exp_f, logic [3:0] exp_c, string req);
    @(negedge clk);
    acc_valid[u] = 1'b1; acc_addr[u] = a; acc_kind[u] = k; acc_priv[u] = p;
    @(negedge clk);
    acc_valid[u] = 1'b0;
    check(req, $sformatf("fault @%08h kind %0d", a, k), 32'(resp_fault[u]), 32'(exp_f));
    check(req, $sformatf("cause @%08h kind %0d", a, k), 32'(resp_cause[u]), 32'(exp_c));
  endtask

  task automatic t_reset();
    check("R14", "resp_valid after reset", 32'(resp_valid[0]), 32'd0);
    expect_read(0, 12'h3A0, PM, 32'h0, 1'b0, "R14");
    expect_read(0, 12'h3B3, PM, 32'h0, 1'b0, "R14");
    expect_access(0, 32'h1234, KL, PU, 1'b0, 4'd0, "R11");
  endtask

  task automatic t_probe();
    expect_read(0, 12'h3B4, PM, 32'h0, 1'b1, "R2");
    expect_read(0, 12'h3BF, PM, 32'h0, 1'b1, "R2");
    expect_read(0, 12'h3A1, PM, 32'h0, 1'b1, "R2");
    expect_read(1, 12'h3B1, PM, 32'h0, 1'b0, "R2");
    expect_read(1, 12'h3B2, PM, 32'h0, 1'b1, "R2");
  endtask

  task automatic t_user_csr();
    expect_read(0, 12'h3A0, PU, 32'h0, 1'b1, "R3");
    expect_read(0, 12'h300, PU, 32'h0, 1'b1, "R3");
    csr_write(0, 12'h3B2, 32'h100, PU);
    expect_read(0, 12'h3B2, PM, 32'h0, 1'b0, "R3");
    expect_read(0, 12'h300, PM, 32'h0, 1'b0, "R3");
  endtask

  task automatic t_gran();
    csr_write(0, 12'h3B0, 32'hFFFF_FFFF, PM);
    expect_read(0, 12'h3B0, PM, 32'h3FFF_FFFC, 1'b0, "R4");
    csr_write(1, 12'h3B0, 32'hFFFF_FFFF, PM);
    expect_read(1, 12'h3B0, PM, 32'h3FFF_FFFF, 1'b0, "R4");
  endtask

  task automatic t_modes();
    csr_write(0, 12'h3A0, 32'h08, PM);
    expect_read(0, 12'h3A0, PM, 32'h08, 1'b0, "R5");
    csr_write(0, 12'h3A0, 32'h10, PM);
    expect_read(0, 12'h3A0, PM, 32'h08, 1'b0, "R5");
    csr_write(0, 12'h3A0, 32'h18, PM);
    expect_read(0, 12'h3A0, PM, 32'h18, 1'b0, "R5");
    csr_write(0, 12'h3A0, 32'h6F, PM);
    expect_read(0, 12'h3A0, PM, 32'h0F, 1'b0, "R5");
    csr_write(1, 12'h3A0, 32'h10, PM);
    expect_read(1, 12'h3A0, PM, 32'h10, 1'b0, "R5");
    csr_write(1, 12'h3A0, 32'h0F0F_0F0F, PM);
    expect_read(1, 12'h3A0, PM, 32'h0000_0F0F, 1'b0, "R1");
    csr_write(0, 12'h3A0, 32'h0, PM);
    csr_write(1, 12'h3A0, 32'h0, PM);
  endtask

  task automatic t_napot();
    csr_write(0, 12'h3B0, 32'h1FFF, PM);
    csr_write(0, 12'h3B1, 32'hFFFF_FFFF, PM);
    csr_write(0, 12'h3A0, 32'h0000_191C, PM);
    expect_read(0, 12'h3B0, PM, 32'h1FFC, 1'b0, "R4");
    expect_read(0, 12'h3A0, PM, 32'h0000_191C, 1'b0, "R1");
    expect_access(0, 32'h0000_0000, KL, PU, 1'b1, 4'd5, "R10");
    expect_access(0, 32'h0000_0000, KF, PU, 1'b0, 4'd0, "R8");
    expect_access(0, 32'h0000_0000, KS, PU, 1'b1, 4'd7, "R10");
    expect_access(0, 32'h0000_FFFC, KL, PU, 1'b1, 4'd5, "R9");
    expect_access(0, 32'h0001_0000, KL, PU, 1'b0, 4'd0, "R8");
    expect_access(0, 32'h0001_0000, KS, PU, 1'b1, 4'd7, "R10");
    expect_access(0, 32'h0002_0000, KF, PU, 1'b1, 4'd1, "R10");
    expect_access(0, 32'h0000_0000, KL, PM, 1'b0, 4'd0, "R12");
    csr_write(0, 12'h3A0, 32'h0, PM);
  endtask

  task automatic t_tor();
    csr_write(0, 12'h3B0, 32'h100, PM);
    csr_write(0, 12'h3B1, 32'h200, PM);
    csr_write(0, 12'h3A0, 32'h0000_0B0F, PM);
    expect_access(0, 32'h0000_0000, KF, PU, 1'b0, 4'd0, "R6");
    expect_access(0, 32'h0000_03FC, KF, PU, 1'b0, 4'd0, "R6");
    expect_access(0, 32'h0000_0400, KF, PU, 1'b1, 4'd1, "R6");
    expect_access(0, 32'h0000_0400, KL, PU, 1'b0, 4'd0, "R6");
    expect_access(0, 32'h0000_07FC, KS, PU, 1'b0, 4'd0, "R6");
    expect_access(0, 32'h0000_0800, KL, PU, 1'b1, 4'd5, "R11");
    csr_write(0, 12'h3A0, 32'h0000_0B00, PM);
    expect_access(0, 32'h0000_03FC, KL, PU, 1'b1, 4'd5, "R6");
    expect_access(0, 32'h0000_0800, KL, PM, 1'b0, 4'd0, "R12");
    expect_access(0, 32'h0000_0400, KF, PM, 1'b0, 4'd0, "R12");
  endtask

  task automatic t_na4();
    csr_write(1, 12'h3B0, 32'h40, PM);
    csr_write(1, 12'h3A0, 32'h11, PM);
    expect_access(1, 32'h0000_0100, KL, PU, 1'b0, 4'd0, "R7");
    expect_access(1, 32'h0000_0103, KL, PU, 1'b0, 4'd0, "R7");
    expect_access(1, 32'h0000_0104, KL, PU, 1'b1, 4'd5, "R7");
    expect_access(1, 32'h0000_00FC, KL, PU, 1'b1, 4'd5, "R7");
    expect_access(1, 32'h0000_0100, KS, PU, 1'b1, 4'd7, "R7");
  endtask

  task automatic t_lock();
    csr_write(0, 12'h3A0, 32'h0000_8B00, PM);
    expect_read(0, 12'h3A0, PM, 32'h0000_8B00, 1'b0, "R12");
    expect_access(0, 32'h0000_0400, KF, PM, 1'b1, 4'd1, "R12");
    expect_access(0, 32'h0000_0400, KL, PM, 1'b0, 4'd0, "R12");
    csr_write(0, 12'h3A0, 32'h0000_000F, PM);
    expect_read(0, 12'h3A0, PM, 32'h0000_8B0F, 1'b0, "R12");
    csr_write(0, 12'h3B1, 32'h999, PM);
    expect_read(0, 12'h3B1, PM, 32'h200, 1'b0, "R12");
    csr_write(0, 12'h3B0, 32'h80, PM);
    expect_read(0, 12'h3B0, PM, 32'h80, 1'b0, "R12");
    expect_access(0, 32'h0000_0200, KS, PU, 1'b0, 4'd0, "R6");
  endtask

  task automatic t_timing();
    @(negedge clk);
    acc_valid[0] = 1'b1; acc_addr[0] = 32'h0; acc_kind[0] = KL; acc_priv[0] = PU;
    #1;
    check("R13", "resp_valid same cycle", 32'(resp_valid[0]), 32'd0);
    @(negedge clk);
    acc_valid[0] = 1'b0;
    check("R13", "resp_valid next cycle", 32'(resp_valid[0]), 32'd1);
    @(negedge clk);
    check("R13", "resp_valid after idle", 32'(resp_valid[0]), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_probe();
    t_user_csr();
    t_gran();
    t_modes();
    t_napot();
    t_tor();
    t_na4();
    t_timing();
    t_lock();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule